// File: doc/BRIEF.md
# Sticky Floating Exception Status Merger

This block keeps the sticky exception bits of a floating-point status register correct after each completed operation. The execution hardware can raise the invalid and underflow sticky bits in cases where IEEE 754 does not call for them: invalid on a non-finite input, underflow on an exact tiny result. On every completion strobe the block takes the status word the hardware left behind. It drops any invalid or underflow bit that was not already set after the previous operation, then ORs in the exceptions the current operation really produced. The result is the new status, and a saved copy of it becomes the reference for the next operation.

The current operation's exceptions arrive on a bus as wide as the status word, aligned to the status bit positions. Only the five exception positions (inexact, invalid, divide-by-zero, underflow, overflow) are taken from it. A five-bit per-kind enable and a global enable decide whether a software trap is requested. The trap request is a single-cycle pulse that appears in the same cycle as the updated status.

Top module: `fp_sticky_merge`

## Requirements
- R1: Synchronous active-low reset clears `stat_out` and `saved_out` to zero and deasserts `trap_req`.
- R2: On an `op_done` strobe, the invalid bit (status bit 1) and underflow bit (status bit 3) of `stat_in` reach `stat_out` only if the same bit is set in `saved_out` before that operation.
- R3: On an `op_done` strobe, every other bit set in `stat_in` is kept in `stat_out`; the block never clears it.
- R4: On an `op_done` strobe, `exc_in` bits 0 (inexact), 1 (invalid), 2 (divide-by-zero), 3 (underflow) and 4 (overflow) are ORed into `stat_out`. All other `exc_in` bits have no effect on `stat_out`.
- R5: After each strobe, `saved_out` equals the new `stat_out`.
- R6: `trap_req` is raised when `trap_glb` is 1 and some exception kind is set both in `exc_in` and in `trap_en`. `trap_en` bit k enables kind k, in the order inexact, invalid, divide-by-zero, underflow, overflow for k = 0..4.
- R7: With `trap_glb` at 0, `trap_req` stays low whatever `exc_in` and `trap_en` are.
- R8: `trap_req` is high for exactly the one cycle after the strobe edge, the same cycle in which `stat_out` shows the update.
- R9: Without a strobe, `stat_out` and `saved_out` hold their values whatever the other inputs do, and `trap_req` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_done | input | 1 | One strobe per completed operation |
| stat_in | input | STAT_W | Status word as left by the hardware |
| exc_in | input | STAT_W | Exceptions of the current operation, aligned to status positions |
| trap_en | input | 5 | Per-kind trap enables |
| trap_glb | input | 1 | Global software trap enable |
| stat_out | output | STAT_W | Merged status |
| saved_out | output | STAT_W | Saved copy of the status after the last operation |
| trap_req | output | 1 | One-cycle trap request |

## Verification
The bench runs pairs of operations. The first operation of a pair sets up the saved copy with each of the four combinations of invalid and underflow. The second operation then sweeps every 8-bit status word against a varied set of exception words that include bits outside the five kinds. This separates bits that are cleared because they were absent before from bits kept because they were present before, from bits that must never be touched, and from exception bits that must be ignored. Trap enables and the global enable vary along with the exceptions, so a trap from a disabled kind or with the global enable off shows up as an error. A cycle with no strobe and changed inputs follows each pair and exposes any hold or pulse-length fault.

// File: rtl/fsx_pkg.sv
// Package: shared constants for the sticky exception merger.
// Assumes five exception kinds in a fixed order used by the enable vector.
package fsx_pkg;
    localparam int NKIND = 5;
    localparam int K_INX = 0;
    localparam int K_INV = 1;
    localparam int K_DZ  = 2;
    localparam int K_UND = 3;
    localparam int K_OVF = 4;
    typedef logic [NKIND-1:0] kind_vec_t;
endpackage

// File: rtl/fsx_posmap.sv
// Module: maps the exception kinds onto status bit positions.
// Builds the mask of all kind positions and the mask of the bits that may be
// scrubbed (invalid, underflow), and extracts the per-kind vector from exc_in.
// Assumes all positions are distinct and below STAT_W.
module fsx_posmap
    import fsx_pkg::*;
#(
    parameter int STAT_W  = 8,
    parameter int POS_INX = 0,
    parameter int POS_INV = 1,
    parameter int POS_DZ  = 2,
    parameter int POS_UND = 3,
    parameter int POS_OVF = 4
) (
    input  logic [STAT_W-1:0] exc_in,
    output logic [STAT_W-1:0] kind_mask,
    output logic [STAT_W-1:0] scrub_mask,
    output kind_vec_t         kinds
);
    localparam int POS_TAB [NKIND] = '{POS_INX, POS_INV, POS_DZ, POS_UND, POS_OVF};

    // Pick each kind's bit out of the aligned exception word.
    for (genvar k = 0; k < NKIND; k++) begin : g_pick
        assign kinds[k] = exc_in[POS_TAB[k]];
    end

    // Form the position masks from the table.
    always_comb begin
        kind_mask  = '0;
        scrub_mask = '0;
        for (int k = 0; k < NKIND; k++) begin
            kind_mask[POS_TAB[k]] = 1'b1;
        end
        scrub_mask[POS_INV] = 1'b1;
        scrub_mask[POS_UND] = 1'b1;
    end
endmodule

// File: rtl/fsx_scrub.sv
// Module: merges one operation into the status word.
// Scrubbed bits survive only if set in the saved copy; the genuine
// exceptions are ORed afterwards so they can set any kind bit.
module fsx_scrub #(
    parameter int STAT_W = 8
) (
    input  logic [STAT_W-1:0] stat_in,
    input  logic [STAT_W-1:0] saved,
    input  logic [STAT_W-1:0] exc_in,
    input  logic [STAT_W-1:0] kind_mask,
    input  logic [STAT_W-1:0] scrub_mask,
    output logic [STAT_W-1:0] merged
);
    logic [STAT_W-1:0] drop;

    // Bits to drop: scrub candidates not present before this operation.
    always_comb begin
        drop   = scrub_mask & ~saved;
        merged = (stat_in & ~drop) | (exc_in & kind_mask);
    end
endmodule

// File: rtl/fsx_trap.sv
// Module: decides whether the current exceptions request a software trap.
// Purely combinational; the caller registers the result.
module fsx_trap
    import fsx_pkg::*;
(
    input  kind_vec_t kinds,
    input  kind_vec_t enables,
    input  logic      global_en,
    output logic      want_trap
);
    // Any enabled kind raised while the global enable is on.
    always_comb begin
        want_trap = global_en & (|(kinds & enables));
    end
endmodule

// File: rtl/fp_sticky_merge.sv
// Module: top of the sticky floating exception status merger.
// On each op_done strobe it registers the merged status, copies it into the
// saved register and raises a one-cycle trap request when enabled.
// Assumes op_done marks exactly one completed operation per high cycle.
module fp_sticky_merge
    import fsx_pkg::*;
#(
    parameter int STAT_W  = 8,
    parameter int POS_INX = 0,
    parameter int POS_INV = 1,
    parameter int POS_DZ  = 2,
    parameter int POS_UND = 3,
    parameter int POS_OVF = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_done,
    input  logic [STAT_W-1:0] stat_in,
    input  logic [STAT_W-1:0] exc_in,
    input  logic [NKIND-1:0]  trap_en,
    input  logic              trap_glb,
    output logic [STAT_W-1:0] stat_out,
    output logic [STAT_W-1:0] saved_out,
    output logic              trap_req
);
    logic [STAT_W-1:0] kind_mask;
    logic [STAT_W-1:0] scrub_mask;
    logic [STAT_W-1:0] merged;
    kind_vec_t         kinds;
    logic              want_trap;
    logic [STAT_W-1:0] stat_q;
    logic [STAT_W-1:0] saved_q;
    logic              trap_q;

    fsx_posmap #(
        .STAT_W(STAT_W), .POS_INX(POS_INX), .POS_INV(POS_INV),
        .POS_DZ(POS_DZ), .POS_UND(POS_UND), .POS_OVF(POS_OVF)
    ) i_posmap (
        .exc_in(exc_in), .kind_mask(kind_mask),
        .scrub_mask(scrub_mask), .kinds(kinds)
    );

    fsx_scrub #(.STAT_W(STAT_W)) i_scrub (
        .stat_in(stat_in), .saved(saved_q), .exc_in(exc_in),
        .kind_mask(kind_mask), .scrub_mask(scrub_mask), .merged(merged)
    );

    fsx_trap i_trap (
        .kinds(kinds), .enables(trap_en),
        .global_en(trap_glb), .want_trap(want_trap)
    );

    // Status and saved copy update once per strobe, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q  <= '0;
            saved_q <= '0;
        end else if (op_done) begin
            stat_q  <= merged;
            saved_q <= merged;
        end
    end

    // Trap request pulses in the cycle the update becomes visible.
    always_ff @(posedge clk) begin
        if (!rst_n) trap_q <= 1'b0;
        else        trap_q <= op_done & want_trap;
    end

    assign stat_out  = stat_q;
    assign saved_out = saved_q;
    assign trap_req  = trap_q;

    // R3
    keep_other_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |=> ((($past(stat_in) & ~scrub_mask) & ~stat_out) == '0));

    // R4
    exc_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |=> ((($past(exc_in) & kind_mask) & ~stat_out) == '0));

    // R5
    saved_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |=> (saved_out == stat_out));

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_done |=> ($stable(stat_out) && $stable(saved_out) && !trap_req));

    // R7
    no_glb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && !trap_glb) |=> !trap_req);

    // R8
    trap_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> $past(op_done));
endmodule

// File: tb/test_fp_sticky_merge.sv
module test_fp_sticky_merge;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         op_done = 1'b0;
    logic [W-1:0] stat_in = '0;
    logic [W-1:0] exc_in = '0;
    logic [4:0]   trap_en = '0;
    logic         trap_glb = 1'b0;
    logic [W-1:0] stat_out;
    logic [W-1:0] saved_out;
    logic         trap_req;

    int checks = 0;
    int fails = 0;
    logic [W-1:0] m_saved = '0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    fp_sticky_merge #(.STAT_W(W)) i_fp_sticky_merge (
        .clk(clk), .rst_n(rst_n), .op_done(op_done), .stat_in(stat_in),
        .exc_in(exc_in), .trap_en(trap_en), .trap_glb(trap_glb),
        .stat_out(stat_out), .saved_out(saved_out), .trap_req(trap_req)
    );

    task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // Bench model: invalid (bit 1) and underflow (bit 3) kept only if saved.
    function automatic logic [W-1:0] model(logic [W-1:0] s, logic [W-1:0] e,
                                           logic [W-1:0] sv);
        logic [W-1:0] keep;
        keep = (s & 8'hF5) | (s & sv & 8'h0A);
        return keep | (e & 8'h1F);
    endfunction

    task automatic do_op(logic [W-1:0] s, logic [W-1:0] e, logic [4:0] en, logic g);
        logic [W-1:0] exp;
        logic         texp;
        @(negedge clk);
        stat_in = s; exc_in = e; trap_en = en; trap_glb = g; op_done = 1'b1;
        exp  = model(s, e, m_saved);
        texp = g && ((e[4:0] & en) != 5'd0);
        @(negedge clk);
        op_done = 1'b0;
        chk("R2/R3/R4 status", stat_out, exp);
        chk("R5 saved", saved_out, exp);
        chk(g ? "R6/R8 trap" : "R7 trap", {7'd0, trap_req}, {7'd0, texp});
        m_saved = exp;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 status", stat_out, 8'h00);
        chk("R1 saved", saved_out, 8'h00);
        chk("R1 trap", {7'd0, trap_req}, 8'h00);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) begin
            for (int b = 0; b < 256; b++) begin
                for (int j = 0; j < 8; j++) begin
                    logic [W-1:0] e1, e2, a;
                    logic [W-1:0] hold_s;
                    e1 = (i[0] ? 8'h02 : 8'h00) | (i[1] ? 8'h08 : 8'h00);
                    a  = 8'h5A ^ W'(b);
                    do_op(a, e1, 5'd0, 1'b0);
                    e2 = W'((j * 37 + b * 3) & 8'hFF);
                    if (j == 0) e2 = 8'h00;
                    if (j == 1) e2 = 8'hE0;
                    do_op(W'(b), e2, 5'((b * 7 + j) & 31), j[0] | j[2]);
                    // R9: no strobe, inputs change, nothing moves.
                    hold_s = stat_out;
                    @(negedge clk);
                    stat_in = ~stat_in; exc_in = 8'hFF; trap_en = 5'h1F; trap_glb = 1'b1;
                    @(negedge clk);
                    chk("R9 hold status", stat_out, hold_s);
                    chk("R9 hold saved", saved_out, hold_s);
                    chk("R8/R9 trap low", {7'd0, trap_req}, 8'h00);
                end
            end
        end
        // R1 again mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 status", stat_out, 8'h00);
        chk("R1 saved", saved_out, 8'h00);
        rst_n = 1'b1;
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 190000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=done");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule